// File: doc/BRIEF.md
# Valley Pulse Qualifier for Zero-Voltage Switching

This block sits between the demagnetization comparator of a boost converter's auxiliary winding and the switching controller. After the power switch turns off and the inductor has released its energy, the switch drain voltage rings. The comparator output goes high while the auxiliary voltage is positive. It drops low just before each local minimum of that ringing. The block turns each qualified high-to-low transition into a one-cycle turn-on trigger, called the valley pulse.

A falling edge counts only when the comparator has been high, without interruption, for a minimum number of clock cycles beforehand. A short spurious high or a glitch edge therefore produces nothing. The raw comparator signal is asynchronous, so it first passes through a two-stage synchronizer. Variable-frequency control does not always turn the switch on at the first valley. For that reason the block also keeps a saturating count of the valley pulses seen since the last turn-off. The controller can compare this count with the valley it has chosen.

Top module: `valley_qualifier`

## Requirements
- R1: A qualified high-to-low change on `cmp_raw` applied before clock edge k produces `valley_pulse` high in the cycle after edge k+2: two synchronizer stages plus one output register.
- R2: A falling edge is qualified only when the synchronized comparator was high on at least `MIN_HIGH_CYC` consecutive clock edges immediately before the low sample.
- R3: A falling edge that ends a high run shorter than `MIN_HIGH_CYC` cycles produces no pulse. Any low sample restarts the high-time measurement from zero.
- R4: `valley_pulse` is never high for two consecutive cycles.
- R5: While `gate_on` is 1 at the edge where a qualified fall is registered, no pulse is produced and the valley count does not advance.
- R6: `valley_count` becomes 0 on the edge following any cycle with `gate_on` = 1.
- R7: With `gate_on` = 0, `valley_count` increases by exactly 1 in the same cycle that each `valley_pulse` appears, and otherwise holds.
- R8: `valley_count` saturates at 2^`CNT_W`-1 (15 by default) and does not wrap.
- R9: While `rst_n` is 0, `valley_pulse` is 0 and `valley_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous demagnetization comparator output, 1 = auxiliary voltage above zero |
| gate_on | input | 1 | Current power-switch gate state, 1 = switch on |
| valley_pulse | output | 1 | One-cycle trigger for a qualified valley |
| valley_count | output | CNT_W | Saturating number of valley pulses since the last turn-off |

## Verification
A high-time counter that clears late or arms early shows up at `valley_pulse` on the first fall that ends a run of `MIN_HIGH_CYC`-1 or `MIN_HIGH_CYC` highs. That happens three cycles after the raw edge, as either a missing pulse or an extra one. A gate interlock that is wrong shows up in the same cycle as the suppressed fall. A counter fault in clearing, stepping or saturation shows up on the next pulse, or on the first cycle after `gate_on` drops. The bench compares both outputs every cycle against a history-based model, so each such fault is reported within one cycle of the edge that exposes it.

// File: rtl/valley_qualifier_pkg.sv
package valley_qualifier_pkg;

  // Saturating increment used by both the high-time and valley counters.
  function automatic logic [15:0] sat_inc(input logic [15:0] value, input logic [15:0] limit);
    return (value >= limit) ? limit : value + 16'd1;
  endfunction

  // A falling edge is qualified once the preceding high run reaches the minimum.
  function automatic logic run_is_long(input logic [15:0] run, input logic [15:0] min_run);
    return run >= min_run;
  endfunction

endpackage

// File: rtl/vq_sync.sv
module vq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/vq_edge_qual.sv
module vq_edge_qual #(
  parameter int MIN_HIGH_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_s,
  input  logic gate_on,
  output logic valley_evt,
  output logic valley_pulse
);
  import valley_qualifier_pkg::*;

  localparam int HI_W = $clog2(MIN_HIGH_CYC + 1);

  logic [HI_W-1:0] hi_run;
  logic            cmp_prev;
  logic            armed_w;
  logic            fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      cmp_prev <= 1'b0;
    end else begin
      cmp_prev <= cmp_s;
      if (!cmp_s) hi_run <= '0;
      else        hi_run <= HI_W'(sat_inc(16'(hi_run), 16'(MIN_HIGH_CYC)));
    end
  end

  assign armed_w    = run_is_long(16'(hi_run), 16'(MIN_HIGH_CYC));
  assign fall_w     = cmp_prev && !cmp_s;
  assign valley_evt = fall_w && armed_w && !gate_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valley_pulse <= 1'b0;
    else        valley_pulse <= valley_evt;
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valley_pulse |=> !valley_pulse);

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |=> !valley_pulse);

  assert_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valley_pulse |-> ($past(armed_w) && $past(fall_w)));

  assert_run_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_s |=> (hi_run == '0));
endmodule

// File: rtl/vq_counter.sv
module vq_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic             valley_evt,
  output logic [CNT_W-1:0] count
);
  import valley_qualifier_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (gate_on)    count <= '0;
    else if (valley_evt) count <= CNT_W'(sat_inc(16'(count), 16'(CNT_MAX)));
  end

  assert_count_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |=> (count == '0));

  assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !gate_on) |=> (count == CNT_MAX));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/valley_qualifier.sv
module valley_qualifier #(
  parameter int MIN_HIGH_CYC = 40,
  parameter int CNT_W        = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             gate_on,
  output logic             valley_pulse,
  output logic [CNT_W-1:0] valley_count
);
  logic cmp_s;
  logic valley_evt;

  vq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_raw),
    .q_sync  (cmp_s)
  );

  vq_edge_qual #(.MIN_HIGH_CYC(MIN_HIGH_CYC)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_s        (cmp_s),
    .gate_on      (gate_on),
    .valley_evt   (valley_evt),
    .valley_pulse (valley_pulse)
  );

  vq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_on    (gate_on),
    .valley_evt (valley_evt),
    .count      (valley_count)
  );

  assert_count_follows_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_pulse && $past(valley_count) != '1) |-> (valley_count == $past(valley_count) + CNT_W'(1)));
endmodule

// File: tb/valley_qualifier_test.sv
module valley_qualifier_test;
  localparam int MIN    = 40;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int HLEN   = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 1'b0;
  logic gate_on = 1'b0;
  logic valley_pulse;
  logic [CNT_W-1:0] valley_count;

  int checks = 0;
  int errors = 0;
  int j = 0;
  int exp_cnt = 0;
  logic prev_pulse = 1'b0;
  bit done = 1'b0;
  logic hist_raw [0:HLEN-1];
  logic hist_gate[0:HLEN-1];

  always #2.5 clk = ~clk;

  valley_qualifier #(.MIN_HIGH_CYC(MIN), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .gate_on(gate_on),
    .valley_pulse(valley_pulse), .valley_count(valley_count)
  );

  function automatic logic rawh(int k);
    return (k < 0) ? 1'b0 : hist_raw[k];
  endfunction

  function automatic logic gateh(int k);
    return (k < 0) ? 1'b0 : hist_gate[k];
  endfunction

  // Length of the unbroken high run ending at sample k, capped at MIN.
  function automatic int run_len(int k);
    int n = 0;
    while (n < MIN && rawh(k - n)) n++;
    return n;
  endfunction

  // Sample outputs for step j, then drive inputs for step j.
  task automatic step(input logic r, input logic g);
    logic fell, longrun, gblk, exp_p;
    fell    = rawh(j - 4) && !rawh(j - 3);
    longrun = run_len(j - 4) >= MIN;
    gblk    = gateh(j - 1);
    exp_p   = fell && longrun && !gblk;
    if (gblk) exp_cnt = 0;
    else if (exp_p && exp_cnt < CMAX) exp_cnt++;

    checks++;
    if (valley_pulse !== exp_p) begin
      errors++;
      if (exp_p)
        $display("FAIL R1/R2 step %0d: pulse actual %b expected %b", j, valley_pulse, exp_p);
      else if (fell && !longrun)
        $display("FAIL R3 step %0d: pulse actual %b expected %b", j, valley_pulse, exp_p);
      else if (fell && gblk)
        $display("FAIL R5 step %0d: pulse actual %b expected %b", j, valley_pulse, exp_p);
      else
        $display("FAIL R1 step %0d: pulse actual %b expected %b", j, valley_pulse, exp_p);
    end
    checks++;
    if (valley_count !== CNT_W'(exp_cnt)) begin
      errors++;
      if (gblk)
        $display("FAIL R6 step %0d: count actual %0d expected %0d", j, valley_count, exp_cnt);
      else if (exp_cnt == CMAX)
        $display("FAIL R8 step %0d: count actual %0d expected %0d", j, valley_count, exp_cnt);
      else
        $display("FAIL R7 step %0d: count actual %0d expected %0d", j, valley_count, exp_cnt);
    end
    checks++;
    if (prev_pulse === 1'b1 && valley_pulse === 1'b1) begin
      errors++;
      $display("FAIL R4 step %0d: pulse actual %b expected %b", j, valley_pulse, 1'b0);
    end
    prev_pulse = valley_pulse;

    if (j < HLEN) begin
      hist_raw[j]  = r;
      hist_gate[j] = g;
    end
    cmp_raw = r;
    gate_on = g;
    j++;
    @(negedge clk);
  endtask

  task automatic seg(input int hi, input int lo, input logic g);
    for (int i = 0; i < hi; i++) step(1'b1, g);
    for (int i = 0; i < lo; i++) step(1'b0, g);
  endtask

  task automatic gate_pulse(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (4) @(negedge clk);
    // R9: reset state while rst_n is low, even with a toggling comparator
    cmp_raw = 1'b1;
    repeat (3) @(negedge clk);
    cmp_raw = 1'b0;
    @(negedge clk);
    checks++;
    if (valley_pulse !== 1'b0 || valley_count !== '0) begin
      errors++;
      $display("FAIL R9: pulse/count actual %b/%0d expected 0/0", valley_pulse, valley_count);
    end
    rst_n = 1'b1;

    // Directed: exactly MIN highs qualifies (R2), MIN-1 does not (R3)
    seg(MIN, 6, 1'b0);
    seg(MIN - 1, 6, 1'b0);
    // Glitch low inside a long high restarts the measurement (R3)
    seg(30, 1, 1'b0);
    seg(20, 6, 1'b0);
    // Short spurious highs (R3)
    for (int k = 1; k < 6; k++) seg(k, 2, 1'b0);
    // Gate on during a qualified fall suppresses the pulse (R5), clears count (R6)
    seg(MIN + 5, 0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    gate_pulse(3);
    // Many valleys to reach saturation (R8)
    for (int k = 0; k < CMAX + 4; k++) seg(MIN + 2, 3, 1'b0);
    gate_pulse(2);

    // Constrained random ringing with occasional turn-on
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      int hi;
      if (sel < 3)      hi = $urandom_range(1, 6);
      else if (sel < 5) hi = MIN - 1 + $urandom_range(0, 2);
      else              hi = $urandom_range(MIN, 2 * MIN);
      seg(hi, $urandom_range(1, 8), 1'b0);
      if ($urandom_range(0, 19) == 0) gate_pulse($urandom_range(1, 10));
      if ($urandom_range(0, 29) == 0) begin
        seg(MIN + 1, 0, 1'b0);
        for (int i = 0; i < $urandom_range(1, 5); i++) step(1'b0, 1'b1);
      end
    end
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule